// File: doc/BRIEF.md
# Load/Store Port Requester Controller

This block sits between a core that wants to perform one memory load or store at a time and a memory-side responder that speaks a strict, acknowledged port handshake. The core hands over a command (direction, 48-bit address, 4-bit length, 64-bit store data) through a valid/ready pair. The controller then raises the matching request line toward the responder and presents the address. It keeps that address steady while the operation is in flight and waits for the responder to accept or reject it. For a store it sends the data strobe, and for a load it captures the returned data. The outcome goes back to the core as a single-cycle pulse.

Nothing is assumed to complete. A rejected address ends the operation with an error pulse. A store is finished only once the responder's busy signal has dropped after the data strobe. A load is finished only on the cycle the responder marks its data valid. A kill input from the core aborts whatever is in flight, is forwarded to the responder, and returns the controller to idle.

The command interface follows valid/ready rules. The core may hold `cmd_valid` high for as long as it likes, and a command is taken only on a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high only while the controller is idle and the responder's busy signal is low, so the core is held back for the whole of an operation. Results carry no back-pressure: each pulse lasts one cycle, and `rsp_rdata` holds its value until the next load completes.

Top module: `lsport_requester`

## Requirements
- R1: After reset the controller is idle: no request line, no address valid, no store strobe, no done or error pulse, `rsp_rdata` equals zero, and `cmd_ready` is high while `prt_busy` is low.
- R2: A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low while an operation is in flight and while `prt_busy` is high, and a command offered then does not start an operation.
- R3: While an operation is in flight, exactly one request line is high. `prt_st_req` is high for a store command (`cmd_is_store`=1) and `prt_ld_req` is high for a load (`cmd_is_store`=0). The line stays high until the operation ends.
- R4: `prt_addr_vld` rises on the cycle after the command is taken, together with the command's address on `prt_addr`. The address does not change for as long as `prt_addr_vld` stays high.
- R5: For a store, `prt_wdata_vld` is high for exactly one cycle. That cycle comes strictly after a cycle with `prt_addr_ack` high, and `prt_wdata` then carries the command's store data.
- R6: For a load, the controller captures `prt_rdata` on the cycle `prt_ld_vld` is high. In the following cycle `rsp_done` pulses for one cycle and `rsp_rdata` shows the captured value, which it keeps afterwards.
- R7: When `prt_addr_exc` pulses while the address is presented, no store strobe is sent. `rsp_err` pulses for one cycle in the next cycle, and the controller returns to idle.
- R8: For a store, `rsp_done` pulses exactly two cycles after the strobe cycle. That follows the cycle in which busy has been seen low.
- R9: `prt_kill` follows `abort` in the same cycle. An abort returns the controller to idle in the next cycle, with both request lines and address valid low.
- R10: `prt_len` carries the command's 4-bit length unchanged while the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Core command valid |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_is_store | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | 48 | Command byte address |
| cmd_len | input | 4 | Command data length |
| cmd_wdata | input | 64 | Store data |
| abort | input | 1 | Kill the current operation |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle address-exception pulse |
| rsp_rdata | output | 64 | Last captured load data |
| prt_ld_req | output | 1 | Load request to responder |
| prt_st_req | output | 1 | Store request to responder |
| prt_len | output | 4 | Length to responder |
| prt_addr | output | 48 | Address to responder |
| prt_addr_vld | output | 1 | Address valid |
| prt_wdata | output | 64 | Store data to responder |
| prt_wdata_vld | output | 1 | One-cycle store data strobe |
| prt_kill | output | 1 | Kill forwarded to responder |
| prt_busy | input | 1 | Responder busy |
| prt_addr_ack | input | 1 | Address accepted pulse |
| prt_addr_exc | input | 1 | Address exception pulse |
| prt_ld_vld | input | 1 | Load data valid pulse |
| prt_rdata | input | 64 | Load data from responder |

## Verification
The properties assume a responder that keeps to its side of the handshake. It raises busy in response to a request and pulses accept or exception at most once per operation. It pulses load-data-valid only after it has accepted a load. It does not start another operation until the request line has dropped. The stimulus uses a behavioural responder that is built this way and enforces these rules itself, with accept and data latencies chosen per scenario, including zero. Core commands are offered under the valid/ready rules, including a command held valid while an operation is in flight.

// File: rtl/lsreq_pkg.sv
package lsreq_pkg;
  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_REQ      = 3'd1,
    S_LD_WAIT  = 3'd2,
    S_ST_SEND  = 3'd3,
    S_ST_DRAIN = 3'd4,
    S_DONE     = 3'd5,
    S_ERR      = 3'd6
  } lsreq_state_e;
endpackage

// File: rtl/lsreq_cmd_reg.sv
module lsreq_cmd_reg #(
  parameter int AW = 48,
  parameter int LW = 4,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          in_is_st,
  input  logic [AW-1:0] in_addr,
  input  logic [LW-1:0] in_len,
  input  logic [DW-1:0] in_wdata,
  output logic          q_is_st,
  output logic [AW-1:0] q_addr,
  output logic [LW-1:0] q_len,
  output logic [DW-1:0] q_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_is_st <= 1'b0;
      q_addr  <= '0;
      q_len   <= '0;
      q_wdata <= '0;
    end else if (load) begin
      q_is_st <= in_is_st;
      q_addr  <= in_addr;
      q_len   <= in_len;
      q_wdata <= in_wdata;
    end
  end
endmodule

// File: rtl/lsreq_fsm.sv
module lsreq_fsm
  import lsreq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic cmd_valid,
  input  logic is_st,
  input  logic busy,
  input  logic addr_ack,
  input  logic addr_exc,
  input  logic ld_vld,
  output logic cmd_ready,
  output logic cmd_take,
  output logic ld_req,
  output logic st_req,
  output logic addr_vld,
  output logic wdata_vld,
  output logic cap_en,
  output logic done,
  output logic err
);
  lsreq_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  logic in_flight;
  assign in_flight = (state_q == S_REQ) || (state_q == S_LD_WAIT) ||
                     (state_q == S_ST_SEND) || (state_q == S_ST_DRAIN);

  assign cmd_ready = (state_q == S_IDLE) && !busy;
  assign cmd_take  = cmd_ready && cmd_valid && !kill;
  assign addr_vld  = in_flight;
  assign ld_req    = in_flight && !is_st;
  assign st_req    = in_flight && is_st;
  assign wdata_vld = (state_q == S_ST_SEND);
  assign cap_en    = (state_q == S_LD_WAIT) && ld_vld;
  assign done      = (state_q == S_DONE);
  assign err       = (state_q == S_ERR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (cmd_take) state_d = S_REQ;
      S_REQ: begin
        if (addr_exc)      state_d = S_ERR;
        else if (addr_ack) state_d = is_st ? S_ST_SEND : S_LD_WAIT;
      end
      S_LD_WAIT:  if (ld_vld) state_d = S_DONE;
      S_ST_SEND:  state_d = S_ST_DRAIN;
      S_ST_DRAIN: if (!busy) state_d = S_DONE;
      S_DONE:     state_d = S_IDLE;
      S_ERR:      state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
    if (kill) state_d = S_IDLE;
  end
endmodule

// File: rtl/lsreq_ldcap.sv
module lsreq_ldcap #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout <= '0;
    else if (cap_en) dout <= din;
  end
endmodule

// File: rtl/lsport_requester.sv
module lsport_requester #(
  parameter int AW = 48,
  parameter int LW = 4,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_is_store,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          abort,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          prt_ld_req,
  output logic          prt_st_req,
  output logic [LW-1:0] prt_len,
  output logic [AW-1:0] prt_addr,
  output logic          prt_addr_vld,
  output logic [DW-1:0] prt_wdata,
  output logic          prt_wdata_vld,
  output logic          prt_kill,
  input  logic          prt_busy,
  input  logic          prt_addr_ack,
  input  logic          prt_addr_exc,
  input  logic          prt_ld_vld,
  input  logic [DW-1:0] prt_rdata
);
  logic take, is_st_q, cap_en;

  assign prt_kill = abort;

  lsreq_cmd_reg #(.AW(AW), .LW(LW), .DW(DW)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .in_is_st (cmd_is_store),
    .in_addr  (cmd_addr),
    .in_len   (cmd_len),
    .in_wdata (cmd_wdata),
    .q_is_st  (is_st_q),
    .q_addr   (prt_addr),
    .q_len    (prt_len),
    .q_wdata  (prt_wdata)
  );

  lsreq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .kill      (abort),
    .cmd_valid (cmd_valid),
    .is_st     (is_st_q),
    .busy      (prt_busy),
    .addr_ack  (prt_addr_ack),
    .addr_exc  (prt_addr_exc),
    .ld_vld    (prt_ld_vld),
    .cmd_ready (cmd_ready),
    .cmd_take  (take),
    .ld_req    (prt_ld_req),
    .st_req    (prt_st_req),
    .addr_vld  (prt_addr_vld),
    .wdata_vld (prt_wdata_vld),
    .cap_en    (cap_en),
    .done      (rsp_done),
    .err       (rsp_err)
  );

  lsreq_ldcap #(.DW(DW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .din    (prt_rdata),
    .dout   (rsp_rdata)
  );
endmodule

// File: rtl/lsreq_chk.sv
module lsreq_chk #(
  parameter int AW = 48,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_is_store,
  input logic          abort,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic [DW-1:0] rsp_rdata,
  input logic          prt_ld_req,
  input logic          prt_st_req,
  input logic [AW-1:0] prt_addr,
  input logic          prt_addr_vld,
  input logic          prt_wdata_vld,
  input logic          prt_kill,
  input logic          prt_busy,
  input logic          prt_addr_ack,
  input logic          prt_addr_exc,
  input logic          prt_ld_vld,
  input logic [DW-1:0] prt_rdata
);
  logic ack_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ack_seen <= 1'b0;
    else if (!prt_addr_vld) ack_seen <= 1'b0;
    else if (prt_addr_ack)  ack_seen <= 1'b1;
  end

  // R1
  ready_needs_idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!prt_busy && !prt_addr_vld));

  // R2
  take_starts_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !abort) |=>
      (prt_addr_vld && (prt_st_req == $past(cmd_is_store))));

  // R3
  one_req_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prt_ld_req && prt_st_req));

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prt_addr_vld |=> (!prt_addr_vld || $stable(prt_addr)));

  // R5
  strobe_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prt_wdata_vld |-> (ack_seen && prt_st_req));

  // R5
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prt_wdata_vld |=> !prt_wdata_vld);

  // R6
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prt_ld_vld && prt_ld_req && ack_seen && !abort) |=>
      (rsp_done && rsp_rdata == $past(prt_rdata)));

  // R7
  exc_to_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prt_addr_exc && prt_addr_vld && !ack_seen && !abort) |=> (rsp_err && !prt_wdata_vld));

  // R9
  kill_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!prt_addr_vld && !prt_ld_req && !prt_st_req));

  // R9
  kill_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prt_kill == abort);

  // R6
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_err));
endmodule

bind lsport_requester lsreq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_is_store  (cmd_is_store),
  .abort         (abort),
  .rsp_done      (rsp_done),
  .rsp_err       (rsp_err),
  .rsp_rdata     (rsp_rdata),
  .prt_ld_req    (prt_ld_req),
  .prt_st_req    (prt_st_req),
  .prt_addr      (prt_addr),
  .prt_addr_vld  (prt_addr_vld),
  .prt_wdata_vld (prt_wdata_vld),
  .prt_kill      (prt_kill),
  .prt_busy      (prt_busy),
  .prt_addr_ack  (prt_addr_ack),
  .prt_addr_exc  (prt_addr_exc),
  .prt_ld_vld    (prt_ld_vld),
  .prt_rdata     (prt_rdata)
);

// File: tb/lsport_requester_bench.sv
`timescale 1ns/1ps
module lsport_requester_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_is_store = 1'b0;
  logic [47:0] cmd_addr = '0;
  logic [3:0]  cmd_len = '0;
  logic [63:0] cmd_wdata = '0;
  logic        abort = 1'b0;
  logic        rsp_done, rsp_err;
  logic [63:0] rsp_rdata;
  logic        prt_ld_req, prt_st_req, prt_addr_vld, prt_wdata_vld, prt_kill;
  logic [3:0]  prt_len;
  logic [47:0] prt_addr;
  logic [63:0] prt_wdata;
  logic        m_busy, m_ack, m_exc, m_ldv;
  logic [63:0] m_rdata;

  always #2 clk = ~clk;

  lsport_requester u_lsport_requester (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_store(cmd_is_store),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
    .abort(abort), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .prt_ld_req(prt_ld_req), .prt_st_req(prt_st_req), .prt_len(prt_len),
    .prt_addr(prt_addr), .prt_addr_vld(prt_addr_vld), .prt_wdata(prt_wdata),
    .prt_wdata_vld(prt_wdata_vld), .prt_kill(prt_kill), .prt_busy(m_busy),
    .prt_addr_ack(m_ack), .prt_addr_exc(m_exc), .prt_ld_vld(m_ldv), .prt_rdata(m_rdata)
  );

  // behavioural responder
  int          cfg_acc = 0, cfg_ld = 0, m_phase = 0, m_cnt = 0;
  bit          cfg_exc = 0;
  logic [47:0] mem_addr = '0;
  logic [3:0]  mem_len = '0;
  logic [63:0] mem_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_ack <= 0; m_exc <= 0; m_ldv <= 0; m_rdata <= '0; m_phase <= 0; m_cnt <= 0;
    end else begin
      m_ack <= 0; m_exc <= 0; m_ldv <= 0;
      if (prt_kill) begin
        m_busy <= 0; m_phase <= 0;
      end else begin
        case (m_phase)
          0: if (prt_ld_req || prt_st_req) begin
               m_busy <= 1; m_cnt <= cfg_acc; m_phase <= 1;
             end
          1: if (m_cnt == 0) begin
               if (cfg_exc) begin
                 m_exc <= 1; m_busy <= 0; m_phase <= 4;
               end else begin
                 m_ack <= 1; mem_addr <= prt_addr; mem_len <= prt_len;
                 m_cnt <= cfg_ld; m_phase <= prt_ld_req ? 2 : 3;
               end
             end else m_cnt <= m_cnt - 1;
          2: if (m_cnt == 0) begin
               m_ldv <= 1; m_rdata <= {16'hA5C3, prt_addr}; m_busy <= 0; m_phase <= 4;
             end else m_cnt <= m_cnt - 1;
          3: if (prt_wdata_vld) begin
               mem_data <= prt_wdata; m_busy <= 0; m_phase <= 4;
             end
          default: if (!prt_ld_req && !prt_st_req) m_phase <= 0;
        endcase
      end
    end
  end

  // port monitor, sampled away from the active edge
  int n_chk = 0, n_fail = 0;
  int strobes = 0, strobe_early = 0, addr_moves = 0, both_req = 0, st_cycles = 0, ld_cycles = 0;
  bit ack_seen_tb = 0, prev_vld = 0;
  logic [47:0] prev_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prt_wdata_vld) begin
        strobes++;
        if (!ack_seen_tb) strobe_early++;
      end
      if (prt_ld_req && prt_st_req) both_req++;
      if (prt_st_req) st_cycles++;
      if (prt_ld_req) ld_cycles++;
      if (prt_addr_vld && prev_vld && prt_addr != prev_addr) addr_moves++;
      if (!prt_addr_vld) ack_seen_tb = 0;
      else if (m_ack) ack_seen_tb = 1;
      prev_vld = prt_addr_vld;
      prev_addr = prt_addr;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    strobes = 0; strobe_early = 0; addr_moves = 0; both_req = 0; st_cycles = 0; ld_cycles = 0;
  endtask

  // issue one command and wait for its outcome
  task automatic do_op(input bit st, input logic [47:0] a, input logic [3:0] len, input logic [63:0] wd,
                       input int acc, input int ld, input bit exc,
                       output int res, output int strobe_at, output int end_at, output bit ldv_before);
    cfg_acc = acc; cfg_ld = ld; cfg_exc = exc;
    clear_mon();
    @(negedge clk);
    cmd_valid = 1; cmd_is_store = st; cmd_addr = a; cmd_len = len; cmd_wdata = wd;
    #0.1;
    check(cmd_ready == 1, "R2 ready before take", {63'd0, cmd_ready}, 64'd1);
    @(negedge clk);
    cmd_valid = 0;
    check(prt_addr_vld && prt_addr == a, "R4 address on cycle after take", {16'd0, prt_addr}, {16'd0, a});
    check(prt_st_req == st && prt_ld_req == !st, "R3 request line", {62'd0, prt_st_req, prt_ld_req}, {62'd0, st, !st});
    res = 0; strobe_at = -1; end_at = -1; ldv_before = 0;
    for (int i = 0; i < 200; i++) begin
      if (prt_wdata_vld) strobe_at = i;
      if (rsp_done || rsp_err) begin
        res = rsp_done ? 1 : 2; end_at = i; break;
      end
      ldv_before = m_ldv;
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    #0.1;
    check(cmd_ready == 0 || !m_busy, "R1 ready in reset", {63'd0, cmd_ready}, 64'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!prt_ld_req && !prt_st_req && !prt_addr_vld, "R1 no request after reset",
          {61'd0, prt_ld_req, prt_st_req, prt_addr_vld}, 64'd0);
    check(!prt_wdata_vld && !rsp_done && !rsp_err, "R1 no pulses after reset",
          {61'd0, prt_wdata_vld, rsp_done, rsp_err}, 64'd0);
    check(rsp_rdata == 0, "R1 rdata zero", rsp_rdata, 64'd0);
    check(cmd_ready == 1, "R1 ready when idle", {63'd0, cmd_ready}, 64'd1);
  endtask

  task automatic test_load(input logic [47:0] a, input logic [3:0] len, input int acc, input int ld);
    int res, sa, ea; bit lb;
    do_op(0, a, len, 64'd0, acc, ld, 0, res, sa, ea, lb);
    check(res == 1, "R6 load done", res, 1);
    check(lb == 1, "R6 done one cycle after data valid", {63'd0, lb}, 64'd1);
    check(rsp_rdata == {16'hA5C3, a}, "R6 load data", rsp_rdata, {16'hA5C3, a});
    check(mem_len == len, "R10 length forwarded", {60'd0, mem_len}, {60'd0, len});
    check(mem_addr == a, "R4 accepted address", {16'd0, mem_addr}, {16'd0, a});
    @(negedge clk);
    check(!rsp_done, "R6 done lasts one cycle", {63'd0, rsp_done}, 64'd0);
    check(rsp_rdata == {16'hA5C3, a}, "R6 rdata held", rsp_rdata, {16'hA5C3, a});
    check(strobes == 0 && st_cycles == 0, "R3 load never drives store side", strobes + st_cycles, 0);
    check(addr_moves == 0 && both_req == 0, "R4 address stable, R3 single line", addr_moves + both_req, 0);
  endtask

  task automatic test_store(input logic [47:0] a, input logic [3:0] len, input logic [63:0] wd, input int acc);
    int res, sa, ea; bit lb;
    do_op(1, a, len, wd, acc, 0, 0, res, sa, ea, lb);
    check(res == 1, "R8 store done", res, 1);
    check(ea - sa == 2, "R8 done two cycles after strobe", ea - sa, 2);
    check(strobes == 1, "R5 exactly one strobe cycle", strobes, 1);
    check(strobe_early == 0, "R5 strobe after accept", strobe_early, 0);
    check(mem_data == wd, "R5 store data", mem_data, wd);
    check(mem_len == len, "R10 length forwarded", {60'd0, mem_len}, {60'd0, len});
    check(ld_cycles == 0 && addr_moves == 0, "R3 store never drives load side, R4 stable", ld_cycles + addr_moves, 0);
    @(negedge clk);
    check(!rsp_done && cmd_ready, "R8 back to idle", {62'd0, rsp_done, cmd_ready}, 64'd1);
  endtask

  task automatic test_exc(input bit st, input int acc);
    int res, sa, ea; bit lb;
    do_op(st, 48'h0000_BAD0_0000, 4'h8, 64'hDEAD, acc, 0, 1, res, sa, ea, lb);
    check(res == 2, "R7 error pulse", res, 2);
    check(strobes == 0, "R7 no strobe after exception", strobes, 0);
    check(!rsp_done, "R7 no done with error", {63'd0, rsp_done}, 64'd0);
    @(negedge clk);
    check(!rsp_err && cmd_ready && !prt_addr_vld, "R7 idle after error",
          {61'd0, rsp_err, cmd_ready, prt_addr_vld}, 64'd2);
  endtask

  task automatic test_busy_cmd();
    int cyc = 0;
    bit ready_seen = 0;
    cfg_acc = 1; cfg_ld = 6; cfg_exc = 0;
    clear_mon();
    @(negedge clk);
    cmd_valid = 1; cmd_is_store = 0; cmd_addr = 48'h0000_0000_1230; cmd_len = 4'h2;
    @(negedge clk);
    cmd_is_store = 1; cmd_addr = 48'h0000_0000_9990; cmd_wdata = 64'h1111;
    while (!rsp_done && cyc < 100) begin
      if (cmd_ready) ready_seen = 1;
      cyc++;
      @(negedge clk);
    end
    cmd_valid = 0;
    check(!ready_seen, "R2 ready low while in flight", {63'd0, ready_seen}, 64'd0);
    check(st_cycles == 0 && strobes == 0, "R2 held command did not start", st_cycles + strobes, 0);
    check(rsp_rdata == {16'hA5C3, 48'h0000_0000_1230}, "R2 first load intact", rsp_rdata,
          {16'hA5C3, 48'h0000_0000_1230});
    repeat (3) @(negedge clk);
    check(!prt_ld_req && !prt_st_req, "R2 no new request", {62'd0, prt_ld_req, prt_st_req}, 64'd0);
  endtask

  task automatic test_kill();
    cfg_acc = 20; cfg_ld = 0; cfg_exc = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_is_store = 0; cmd_addr = 48'h0000_0000_4440; cmd_len = 4'h4;
    @(negedge clk);
    cmd_valid = 0;
    repeat (3) @(negedge clk);
    abort = 1;
    #0.1;
    check(prt_kill == 1, "R9 kill forwarded", {63'd0, prt_kill}, 64'd1);
    @(negedge clk);
    abort = 0;
    #0.1;
    check(!prt_ld_req && !prt_st_req && !prt_addr_vld, "R9 idle after abort",
          {61'd0, prt_ld_req, prt_st_req, prt_addr_vld}, 64'd0);
    check(cmd_ready == 1 && prt_kill == 0, "R9 ready after abort", {62'd0, cmd_ready, prt_kill}, 64'd2);
    check(!rsp_done && !rsp_err, "R9 no result pulse on abort", {62'd0, rsp_done, rsp_err}, 64'd0);
  endtask

  bit finished = 0;
  initial begin
    #600000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_load(48'h0000_0000_1000, 4'h8, 0, 0);
    test_load(48'h7FFF_FFFF_FFF8, 4'h1, 3, 5);
    test_store(48'h0000_0000_2008, 4'h4, 64'h0123_4567_89AB_CDEF, 0);
    test_store(48'hFFFF_FFFF_FFF0, 4'hF, 64'hFEDC_BA98_7654_3210, 4);
    test_exc(0, 2);
    test_exc(1, 0);
    test_busy_cmd();
    test_kill();
    test_load(48'h0000_0000_5550, 4'h2, 1, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule